// File: doc/BRIEF.md
# Mailbox Peripheral Clock Divider Controller

This block gates the clock of each peripheral in a group and gives each one its own divided clock enable, which is derived from the master clock. Each peripheral's divider is not mapped at its own address. Software reaches every divider through a single command register that works like a mailbox. A command word carries a peripheral ID, a one-bit command and a two-bit divider code.

A WRITE command stores the divider code for the addressed peripheral. A READ command copies that peripheral's stored code into a readback register, together with its ID and its current enable state. Enables are changed through a write-one-to-set path and a write-one-to-clear path, and their present state is shown on a status output.

For each peripheral, the block outputs a strobe that is high for one master-clock cycle out of every N cycles, where N is 1, 2, 4 or 8. Peripherals use this strobe as their clock enable. A new divider code only takes effect when that peripheral's divider counter wraps, so no early pulse is produced.

Top module: `pclk_mbox_ctrl`

## Requirements
- R1: After reset, every peripheral is disabled, every stored and active divider code is 00, the readback register is zero and no strobe is high.
- R2: A cycle with `en_set_we` high enables each peripheral whose bit in `en_wdata` is 1. Bits that are 0 leave the enable state unchanged.
- R3: A cycle with `en_clr_we` high disables each peripheral whose bit in `en_wdata` is 1. When set and clear hit the same bit in the same cycle, clear wins.
- R4: `en_status[i]` shows the enable state of peripheral i from the cycle after the set or clear edge.
- R5: A command word with bit [IDW+2] = 1 is a WRITE. It stores the code in bits [1:0] for the peripheral whose ID is in bits [IDW+1:2], provided that ID < NPER.
- R6: A command word with bit [IDW+2] = 0 is a READ. For an ID below NPER, from the next cycle `mbox_rdata` = {enable bit, ID, stored code}, using the same bit positions as the command word.
- R7: A command whose ID is NPER or above changes no stored code. A READ with such an ID loads `mbox_rdata` with zero.
- R8: Code 00 divides by 1, 01 by 2, 10 by 4 and 11 by 8. An enabled peripheral's strobe is high for one cycle in every N. A disabled peripheral's strobe stays low.
- R9: A stored code becomes the active code only at the peripheral's counter wrap, which is the cycle its strobe would fire. The period that is already running finishes with the old code.
- R10: `mbox_rdata` changes only on a READ command. WRITEs and enable changes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | IDW+3 | Command word: code [1:0], ID [IDW+1:2], command [IDW+2] (1 = WRITE) |
| en_set_we | input | 1 | Write strobe for the enable-set path |
| en_clr_we | input | 1 | Write strobe for the enable-clear path |
| en_wdata | input | NPER | One bit per peripheral for set or clear |
| en_status | output | NPER | Current enable state |
| mbox_rdata | output | IDW+3 | Readback: code, ID, enable echo in the top bit |
| clk_en | output | NPER | Per-peripheral divided clock enable strobe |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a divider WRITE and the wrap of that same peripheral's counter. The bench provokes it in a directed case: it issues a WRITE exactly on the cycle a divide-by-8 strobe fires. It then requires the next seven strobes to be absent and the old period to run out before the new rate appears. The second pair is an enable set and an enable clear on the same bit. The bench drives both on one edge and requires the status bit to read cleared. Random traffic also mixes these collisions with READs whose enable echo must reflect the state before the edge.

// File: rtl/pclk_mbox_ctrl.sv
module pclk_mbox_ctrl #(
  parameter int NPER = 16,
  parameter int IDW  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [IDW+2:0]   cmd_wdata,
  input  logic             en_set_we,
  input  logic             en_clr_we,
  input  logic [NPER-1:0]  en_wdata,
  output logic [NPER-1:0]  en_status,
  output logic [IDW+2:0]   mbox_rdata,
  output logic [NPER-1:0]  clk_en
);

  localparam int CW = IDW + 3;

  wire [1:0]     c_code = cmd_wdata[1:0];
  wire [IDW-1:0] c_id   = cmd_wdata[IDW+1:2];
  wire           c_wr   = cmd_wdata[IDW+2];
  wire           id_ok  = (32'(c_id) < NPER);

  logic [NPER-1:0]      en_q;
  logic [NPER-1:0][1:0] pend_v;
  logic [1:0]           rd_code;
  logic                 rd_en;

  wire [NPER-1:0] set_m = en_set_we ? en_wdata : '0;
  wire [NPER-1:0] clr_m = en_clr_we ? en_wdata : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= '0;
    else        en_q <= (en_q | set_m) & ~clr_m;

  assign en_status = en_q;

  always_comb begin
    rd_code = 2'b00;
    rd_en   = 1'b0;
    for (int i = 0; i < NPER; i++)
      if (c_id == IDW'(i)) begin
        rd_code = pend_v[i];
        rd_en   = en_q[i];
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      mbox_rdata <= '0;
    else if (cmd_we && !c_wr)
      mbox_rdata <= id_ok ? {rd_en, c_id, rd_code} : CW'(0);

  for (genvar i = 0; i < NPER; i++) begin : g_per
    logic [1:0] pend, cur;
    logic [2:0] cnt;
    wire  [2:0] lim  = (3'd1 << cur) - 3'd1;
    wire        wrap = (cnt == lim);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        pend <= 2'b00;
      else if (cmd_we && c_wr && id_ok && c_id == IDW'(i))
        pend <= c_code;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= 3'd0;
        cur <= 2'b00;
      end else if (wrap) begin
        cnt <= 3'd0;
        cur <= pend;
      end else begin
        cnt <= cnt + 3'd1;
      end

    assign pend_v[i] = pend;
    assign clk_en[i] = en_q[i] & wrap;
  end

endmodule

// File: rtl/pclk_mbox_ctrl_chk.sv
module pclk_mbox_ctrl_chk #(
  parameter int NPER = 16,
  parameter int IDW  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_we,
  input logic [IDW+2:0]  cmd_wdata,
  input logic            en_set_we,
  input logic            en_clr_we,
  input logic [NPER-1:0] en_wdata,
  input logic [NPER-1:0] en_status,
  input logic [IDW+2:0]  mbox_rdata,
  input logic [NPER-1:0] clk_en
);

  wire is_rd  = cmd_we && !cmd_wdata[IDW+2];
  wire rd_ok  = is_rd && (32'(cmd_wdata[IDW+1:2]) < NPER);
  wire rd_bad = is_rd && !(32'(cmd_wdata[IDW+1:2]) < NPER);

  // R8
  strobe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en & ~en_status) == '0);

  // R3
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_we |=> (en_status & $past(en_wdata)) == '0);

  // R2
  set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set_we && !en_clr_we) |=> (en_status & $past(en_wdata)) == $past(en_wdata));

  // R6
  read_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |=> mbox_rdata[IDW+1:2] == $past(cmd_wdata[IDW+1:2]));

  // R7
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |=> mbox_rdata == '0);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> $stable(mbox_rdata));

endmodule

bind pclk_mbox_ctrl pclk_mbox_ctrl_chk #(.NPER(NPER), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
  .en_set_we(en_set_we), .en_clr_we(en_clr_we), .en_wdata(en_wdata),
  .en_status(en_status), .mbox_rdata(mbox_rdata), .clk_en(clk_en)
);

// File: tb/pclk_mbox_ctrl_tb.sv
module pclk_mbox_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPER = 16;
  localparam int IDW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [IDW+2:0] cmd_wdata = '0;
  logic en_set_we = 1'b0, en_clr_we = 1'b0;
  logic [NPER-1:0] en_wdata = '0;
  logic [NPER-1:0] en_status, clk_en;
  logic [IDW+2:0] mbox_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pclk_mbox_ctrl #(.NPER(NPER), .IDW(IDW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .en_set_we(en_set_we), .en_clr_we(en_clr_we), .en_wdata(en_wdata),
    .en_status(en_status), .mbox_rdata(mbox_rdata), .clk_en(clk_en)
  );

  // reference model from the requirements
  logic [NPER-1:0] m_en;
  logic [1:0] m_pend [NPER];
  logic [1:0] m_cur  [NPER];
  int         m_cnt  [NPER];
  logic [IDW+2:0] m_rd;

  always @(posedge clk) begin
    int id;
    if (!rst_n) begin
      m_en <= '0;
      m_rd <= '0;
      for (int i = 0; i < NPER; i++) begin
        m_pend[i] <= 2'b00; m_cur[i] <= 2'b00; m_cnt[i] <= 0;
      end
    end else begin
      for (int i = 0; i < NPER; i++)
        if (m_cnt[i] == (1 << m_cur[i]) - 1) begin
          m_cnt[i] <= 0; m_cur[i] <= m_pend[i];
        end else m_cnt[i] <= m_cnt[i] + 1;
      id = int'(cmd_wdata[IDW+1:2]);
      if (cmd_we) begin
        if (cmd_wdata[IDW+2]) begin
          if (id < NPER) m_pend[id] <= cmd_wdata[1:0];
        end else if (id < NPER)
          m_rd <= {m_en[id], IDW'(id), m_pend[id]};
        else
          m_rd <= '0;
      end
      m_en <= (m_en | (en_set_we ? en_wdata : '0)) & ~(en_clr_we ? en_wdata : '0);
    end
  end

  function automatic logic [NPER-1:0] exp_strobe();
    logic [NPER-1:0] s;
    for (int i = 0; i < NPER; i++)
      s[i] = m_en[i] && (m_cnt[i] == (1 << m_cur[i]) - 1);
    return s;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check("R8 R9 strobe", 32'(clk_en), 32'(exp_strobe()));
    check("R4 status", 32'(en_status), 32'(m_en));
    check("R6 rdata", 32'(mbox_rdata), 32'(m_rd));
  endtask

  task automatic do_cmd(input bit wr, input int id, input logic [1:0] code);
    cmd_we = 1'b1;
    cmd_wdata = {wr, IDW'(id), code};
    step();
    cmd_we = 1'b0;
  endtask

  task automatic do_en(input bit s, input bit c, input logic [NPER-1:0] m);
    en_set_we = s; en_clr_we = c; en_wdata = m;
    step();
    en_set_we = 1'b0; en_clr_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1
    check("R1 status", 32'(en_status), 0);
    check("R1 strobe", 32'(clk_en), 0);
    check("R1 rdata", 32'(mbox_rdata), 0);
    rst_n = 1'b1;
    step();

    // R5 R8: code per peripheral
    for (int i = 0; i < 4; i++) do_cmd(1'b1, i, 2'(i));
    do_en(1'b1, 1'b0, 16'h000F);
    repeat (20) step();
    do_cmd(1'b0, 2, 2'b00);
    // R6 R5
    check("R5 R6 readback", 32'(mbox_rdata), 32'({1'b1, 5'd2, 2'b10}));

    // R2: set keeps previous bits
    do_en(1'b1, 1'b0, 16'h00F0);
    check("R2 set", 32'(en_status), 32'h00FF);
    // R3: set and clear collide on bit 0
    do_en(1'b1, 1'b1, 16'h0001);
    check("R3 collide", 32'(en_status[0]), 0);

    // R7: out-of-range write aliasing id 4 leaves id 4 alone
    do_cmd(1'b1, 4, 2'b01);
    do_cmd(1'b1, 20, 2'b11);
    do_cmd(1'b0, 4, 2'b00);
    check("R7 alias write", 32'(mbox_rdata[1:0]), 1);
    do_cmd(1'b0, 17, 2'b00);
    check("R7 bad read", 32'(mbox_rdata), 0);
    // R10: writes and enable changes keep readback
    do_cmd(1'b0, 4, 2'b00);
    do_cmd(1'b1, 4, 2'b11);
    do_en(1'b0, 1'b1, 16'h0010);
    check("R10 hold", 32'(mbox_rdata), 32'({1'b1, 5'd4, 2'b01}));

    // R9: code change on the wrap cycle of a /8 peripheral
    do_en(1'b0, 1'b1, 16'hFFFF);
    do_cmd(1'b1, 5, 2'b11);
    do_en(1'b1, 1'b0, 16'h0020);
    cnt = 0;
    while (!clk_en[5] && cnt < 40) begin step(); cnt++; end
    cmd_we = 1'b1; cmd_wdata = {1'b1, 5'd5, 2'b00};
    cnt = 0;
    for (int k = 0; k < 7; k++) begin
      step(); cmd_we = 1'b0;
      if (clk_en[5]) cnt++;
    end
    check("R9 old period", cnt, 0);
    step();
    check("R9 last old strobe", 32'(clk_en[5]), 1);
    step();
    check("R9 new rate", 32'(clk_en[5]), 1);

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      cmd_we = ($urandom % 3) == 0;
      cmd_wdata = {1'($urandom), 5'($urandom % 20), 2'($urandom)};
      en_set_we = ($urandom % 5) == 0;
      en_clr_we = ($urandom % 6) == 0;
      en_wdata = 16'($urandom);
      step();
    end
    cmd_we = 1'b0; en_set_we = 1'b0; en_clr_we = 1'b0;
    step();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule